// File: doc/BRIEF.md
# Two-Level Register Stack Datapath

This block is the execute datapath of a small stack machine. The top two stack entries are held in registers: `topA` is the top and `nextB` is the entry below it. Every deeper entry sits in a small on-chip stack RAM. A decoded operation arrives on `opIn` and takes one decode cycle and one execute cycle. Each operation is either push-type or pop-type, or a no-operation. That class alone decides whether the RAM is written or read.

In decode, the control half does four things. It classifies the operation, moves the depth counter, records the spill address, and gives the synchronous RAM its fill address. The RAM word is therefore ready at its output when the operation reaches execute. In execute, the result goes straight into `topA`, and `nextB` or the RAM is updated in the same cycle. There is no write-back stage and no operand forwarding.

A push whose spill happens in the same cycle that a following pop reads the same RAM word is resolved inside the RAM itself. The RAM uses write-first read behaviour, so the pop sees the word being written. `topA` feeds every attached memory or I/O module directly as write data.

Top module: `stack_core`

## Requirements
- R1: While reset is asserted and after it is released, `topA` and `nextB` are 0, `depth` is 0, and both `ovfFlag` and `unfFlag` are 0.
- R2: Opcode 1 (load immediate) is a push. It takes `imm` in the same cycle as the opcode. After two rising edges, `topA` equals `imm`, `nextB` equals the former `topA`, and the former `nextB` is spilled to the RAM.
- R3: Opcode 2 (load read data) is a push. It takes `rdData` during the cycle after the opcode is presented, and that value appears in `topA` after the second rising edge.
- R4: Opcodes 3 to 7 are pops that write an ALU result into `topA`, with B the left operand. Opcode 3 gives B+A, 4 gives B-A, 5 gives B&A, 6 gives B|A and 7 gives B^A. `nextB` is refilled from the RAM.
- R5: Opcode 8 (pass B) is a pop. It copies `nextB` into `topA` and refills `nextB` from the RAM.
- R6: Opcode 0 and opcodes 9 to 15 are no-operations. They leave `topA`, `nextB`, `depth` and both flags unchanged.
- R7: Spilled values come back in last-in first-out order. This includes a pop issued in the cycle right after a push, with no stall cycle.
- R8: `depth` counts the entries held in the RAM. It changes one rising edge after an operation is presented: +1 for an accepted push and -1 for an accepted pop.
- R9: A push presented while `depth` equals DEPTH sets the sticky `ovfFlag` and has no other effect on `topA`, `nextB` or `depth`.
- R10: A pop presented while `depth` is 0 sets the sticky `unfFlag` and has no other effect on `topA`, `nextB` or `depth`.
- R11: Once set, either flag stays set until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| opIn | input | 4 | Decoded operation code entering decode |
| imm | input | DW | Immediate operand, taken with `opIn` |
| rdData | input | DW | External read data, taken during execute |
| topA | output | DW | Top-of-stack register, also the write data for attached modules |
| nextB | output | DW | Second stack entry |
| depth | output | $clog2(DEPTH+1) | Number of entries held in the stack RAM |
| ovfFlag | output | 1 | Sticky overflow flag |
| unfFlag | output | 1 | Sticky underflow flag |

## Verification
The assertions take for granted that `opIn` is a known 4-bit value on every cycle after reset. They also assume that `rdData` is valid in the execute cycle of a read-data push. Nothing else is assumed, because any opcode outside the push and pop sets is defined as a no-operation and bounds violations are absorbed by the flags. The stimulus drives every opcode value, including the unused ones. It places `rdData` exactly one cycle after its push, and uses push-heavy and pop-heavy random runs so that both stack bounds are crossed while back-to-back push and pop pairs still occur often.

// File: rtl/stk_pkg.sv
package stk_pkg;

  localparam logic [3:0] OP_NOP   = 4'd0;
  localparam logic [3:0] OP_LDI   = 4'd1;
  localparam logic [3:0] OP_LDD   = 4'd2;
  localparam logic [3:0] OP_ADD   = 4'd3;
  localparam logic [3:0] OP_SUB   = 4'd4;
  localparam logic [3:0] OP_AND   = 4'd5;
  localparam logic [3:0] OP_OR    = 4'd6;
  localparam logic [3:0] OP_XOR   = 4'd7;
  localparam logic [3:0] OP_PASSB = 4'd8;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR, ALU_PASSB
  } aluOp_e;

  typedef enum logic [1:0] {
    ASRC_ALU, ASRC_IMM, ASRC_RD
  } aSrc_e;

  // strobes handed from decode to execute
  typedef struct packed {
    logic   push;
    logic   pop;
    aSrc_e  aSrc;
    aluOp_e aluOp;
  } exStrb_t;

endpackage

// File: rtl/stk_ctrl.sv
module stk_ctrl
  import stk_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [3:0]                   opIn,
  output exStrb_t                      exS,
  output logic [$clog2(DEPTH)-1:0]     rdAddr,
  output logic [$clog2(DEPTH)-1:0]     wrAddr,
  output logic [$clog2(DEPTH+1)-1:0]   depth,
  output logic                         ovf,
  output logic                         unf
);

  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  logic    isPush, isPop, goPush, goPop, isFull, isEmpty;
  exStrb_t dec;

  assign isFull  = (depth == FULL);
  assign isEmpty = (depth == '0);

  always_comb begin
    isPush = (opIn == OP_LDI) || (opIn == OP_LDD);
    isPop  = (opIn >= OP_ADD) && (opIn <= OP_PASSB);
    goPush = isPush && !isFull;
    goPop  = isPop && !isEmpty;
    dec.push  = goPush;
    dec.pop   = goPop;
    dec.aSrc  = ASRC_ALU;
    dec.aluOp = ALU_ADD;
    if (opIn == OP_LDI) dec.aSrc = ASRC_IMM;
    if (opIn == OP_LDD) dec.aSrc = ASRC_RD;
    case (opIn)
      OP_SUB:   dec.aluOp = ALU_SUB;
      OP_AND:   dec.aluOp = ALU_AND;
      OP_OR:    dec.aluOp = ALU_OR;
      OP_XOR:   dec.aluOp = ALU_XOR;
      OP_PASSB: dec.aluOp = ALU_PASSB;
      default:  dec.aluOp = ALU_ADD;
    endcase
  end

  // fill address goes to the synchronous RAM during decode
  assign rdAddr = AW'(depth - CW'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      exS    <= '0;
      wrAddr <= '0;
      depth  <= '0;
      ovf    <= 1'b0;
      unf    <= 1'b0;
    end else begin
      exS    <= dec;
      wrAddr <= AW'(depth);
      if (goPush)      depth <= depth + CW'(1);
      else if (goPop)  depth <= depth - CW'(1);
      if (isPush && isFull)  ovf <= 1'b1;
      if (isPop && isEmpty)  unf <= 1'b1;
    end
  end

  // R8
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    depth <= FULL);

  // R8
  pop_depth_chk: assert property (@(posedge clk) disable iff (!rstN)
    goPop |=> depth == $past(depth) - CW'(1));

  // R9
  ovf_reject_chk: assert property (@(posedge clk) disable iff (!rstN)
    (isPush && isFull) |=> ovf && depth == $past(depth));

  // R10
  unf_reject_chk: assert property (@(posedge clk) disable iff (!rstN)
    (isPop && isEmpty) |=> unf && depth == $past(depth));

  // R11
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ovf || unf) |=> (ovf >= $past(ovf)) && (unf >= $past(unf)));

  // R6
  strb_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({exS.push, exS.pop}));

endmodule

// File: rtl/stk_dpath.sv
module stk_dpath
  import stk_pkg::*;
#(
  parameter int DW    = 16,
  parameter int DEPTH = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  exStrb_t                   exS,
  input  logic [$clog2(DEPTH)-1:0]  rdAddr,
  input  logic [$clog2(DEPTH)-1:0]  wrAddr,
  input  logic [DW-1:0]             imm,
  input  logic [DW-1:0]             rdData,
  output logic [DW-1:0]             topA,
  output logic [DW-1:0]             nextB
);

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] ramQ;
  logic [DW-1:0] immQ;
  logic [DW-1:0] aluRes;
  logic [DW-1:0] aNext;

  // stack RAM: synchronous read, write-first on a same-address collision
  always_ff @(posedge clk) begin
    if (exS.push && (wrAddr == rdAddr)) ramQ <= nextB;
    else                                 ramQ <= mem[rdAddr];
    if (exS.push) mem[wrAddr] <= nextB;
  end

  always_comb begin
    case (exS.aluOp)
      ALU_SUB:   aluRes = nextB - topA;
      ALU_AND:   aluRes = nextB & topA;
      ALU_OR:    aluRes = nextB | topA;
      ALU_XOR:   aluRes = nextB ^ topA;
      ALU_PASSB: aluRes = nextB;
      default:   aluRes = nextB + topA;
    endcase
  end

  always_comb begin
    case (exS.aSrc)
      ASRC_IMM: aNext = immQ;
      ASRC_RD:  aNext = rdData;
      default:  aNext = aluRes;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      topA  <= '0;
      nextB <= '0;
      immQ  <= '0;
    end else begin
      immQ <= imm;
      if (exS.push) begin
        topA  <= aNext;
        nextB <= topA;
      end else if (exS.pop) begin
        topA  <= aNext;
        nextB <= ramQ;
      end
    end
  end

  // R2
  push_shift_chk: assert property (@(posedge clk) disable iff (!rstN)
    exS.push |=> nextB == $past(topA));

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!exS.push && !exS.pop) |=> $stable(topA) && $stable(nextB));

  // R5
  passb_chk: assert property (@(posedge clk) disable iff (!rstN)
    (exS.pop && exS.aluOp == ALU_PASSB) |=> topA == $past(nextB));

endmodule

// File: rtl/stack_core.sv
module stack_core
  import stk_pkg::*;
#(
  parameter int DW    = 16,
  parameter int DEPTH = 8
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [3:0]                  opIn,
  input  logic [DW-1:0]               imm,
  input  logic [DW-1:0]               rdData,
  output logic [DW-1:0]               topA,
  output logic [DW-1:0]               nextB,
  output logic [$clog2(DEPTH+1)-1:0]  depth,
  output logic                        ovfFlag,
  output logic                        unfFlag
);

  localparam int AW = $clog2(DEPTH);

  exStrb_t         exS;
  logic [AW-1:0]   rdAddr;
  logic [AW-1:0]   wrAddr;

  stk_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .opIn   (opIn),
    .exS    (exS),
    .rdAddr (rdAddr),
    .wrAddr (wrAddr),
    .depth  (depth),
    .ovf    (ovfFlag),
    .unf    (unfFlag)
  );

  stk_dpath #(.DW(DW), .DEPTH(DEPTH)) u_dpath (
    .clk    (clk),
    .rstN   (rstN),
    .exS    (exS),
    .rdAddr (rdAddr),
    .wrAddr (wrAddr),
    .imm    (imm),
    .rdData (rdData),
    .topA   (topA),
    .nextB  (nextB)
  );

endmodule

// File: tb/stack_core_tb.sv
module stack_core_tb;

  localparam int CLK_PERIOD = 10;
  localparam int DW    = 16;
  localparam int DEPTH = 8;
  localparam int CW    = $clog2(DEPTH+1);
  localparam int MAXN  = 700;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [3:0] opIn = '0;
  logic [DW-1:0] imm = '0;
  logic [DW-1:0] rdData = '0;
  logic [DW-1:0] topA, nextB;
  logic [CW-1:0] depth;
  logic ovfFlag, unfFlag;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stack_core #(.DW(DW), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .rstN(rstN), .opIn(opIn), .imm(imm), .rdData(rdData),
    .topA(topA), .nextB(nextB), .depth(depth),
    .ovfFlag(ovfFlag), .unfFlag(unfFlag)
  );

  // reference model state and per-operation history
  logic [DW-1:0] refMem [DEPTH];
  logic [DW-1:0] mA, mB;
  int mD;
  bit mO, mU;
  logic [DW-1:0] hA [MAXN+4];
  logic [DW-1:0] hB [MAXN+4];
  int  hD [MAXN+4];
  bit  hO [MAXN+4];
  bit  hU [MAXN+4];
  string hTag [MAXN+4];
  logic [3:0] ops [MAXN+4];
  logic [DW-1:0] rdv [MAXN+4];

  task automatic check(string tag, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] aluRef(logic [3:0] o, logic [DW-1:0] b, logic [DW-1:0] a);
    case (o)
      4'd3: return b + a;
      4'd4: return b - a;
      4'd5: return b & a;
      4'd6: return b | a;
      4'd7: return b ^ a;
      default: return b;
    endcase
  endfunction

  // apply one operation to the model; returns the requirement it exercises
  function automatic string modelStep(logic [3:0] o, logic [DW-1:0] iv, logic [DW-1:0] rv);
    if (o == 4'd1 || o == 4'd2) begin
      if (mD == DEPTH) begin mO = 1; return "R9"; end
      refMem[mD] = mB; mD++; mB = mA;
      mA = (o == 4'd1) ? iv : rv;
      return (o == 4'd1) ? "R2" : "R3";
    end else if (o >= 4'd3 && o <= 4'd8) begin
      if (mD == 0) begin mU = 1; return "R10"; end
      mA = aluRef(o, mB, mA);
      mD--; mB = refMem[mD];
      return (o == 4'd8) ? "R5" : "R4";
    end
    return "R6";
  endfunction

  function automatic logic [3:0] pickOp(int mode, int m);
    int r;
    r = $urandom % 100;
    case (mode)
      0: return (m < DEPTH + 4) ? 4'd1 : ((m < 2*DEPTH + 9) ? 4'd8 : 4'd0);
      1: return 4'($urandom % 16);
      2: return (r < 60) ? 4'(1 + $urandom % 2) : 4'($urandom % 16);
      3: return (r < 60) ? 4'(3 + $urandom % 6) : 4'($urandom % 16);
      default: return (m % 2 == 0) ? 4'd1 : 4'($urandom % 2 == 0 ? 3 : 4);
    endcase
  endfunction

  task automatic runPhase(int n, int mode);
    rstN = 1'b0; opIn = '0; imm = '0; rdData = '0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R1", "topA in reset", topA, 0);
    check("R1", "nextB in reset", nextB, 0);
    check("R1", "depth in reset", depth, 0);
    check("R1", "flags in reset", {ovfFlag, unfFlag}, 0);
    rstN = 1'b1;
    mA = '0; mB = '0; mD = 0; mO = 0; mU = 0;
    hA[0] = '0; hB[0] = '0; hD[0] = 0; hO[0] = 0; hU[0] = 0; hTag[0] = "R1";
    for (int m = 0; m < n + 3; m++) begin
      // A/B reflect operations through m-2, depth/flags through m-1
      if (m >= 1) begin
        check(hTag[m-1], "topA", topA, hA[m-1]);
        check((m >= 2 && ops[m-2] >= 4'd3 && ops[m-2] <= 4'd8) ? "R7" : hTag[m-1],
              "nextB", nextB, hB[m-1]);
      end
      check("R8", "depth", depth, hD[m]);
      check((hO[m] != 0) ? "R11" : "R9", "ovfFlag", ovfFlag, hO[m]);
      check((hU[m] != 0) ? "R11" : "R10", "unfFlag", unfFlag, hU[m]);
      ops[m] = (m < n) ? pickOp(mode, m) : 4'd0;
      rdv[m] = DW'($urandom);
      opIn = ops[m];
      imm  = DW'($urandom);
      rdData = (m >= 1) ? rdv[m-1] : DW'($urandom);
      hTag[m+1] = modelStep(ops[m], imm, rdv[m]);
      hA[m+1] = mA; hB[m+1] = mB; hD[m+1] = mD; hO[m+1] = mO; hU[m+1] = mU;
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  initial begin
    void'($urandom(32'd20250));
    @(negedge clk);
    runPhase(2*DEPTH + 12, 0);   // fill past full, drain past empty: R9, R10, R7
    runPhase(40, 4);             // push then pop back to back: R7
    runPhase(400, 1);
    runPhase(400, 2);
    runPhase(400, 3);
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule